// File: doc/BRIEF.md
# Fetch-Stage Keystream Decryption Datapath

This block sits between instruction fetch and instruction decode. Every fetched 32-bit word arrives encrypted in counter mode. The block XORs it with a 32-bit slice of a 128-bit keystream block and passes the plaintext straight on to decode. Each keystream block covers four consecutive instructions. The two low bits of the instruction index inside the current basic block pick the slice. The remaining index bits name the block number, which is the counter value.

Four iterative cipher lanes compute keystream. Each lane is an encrypt-only keyed mixing function with a fixed 13-cycle latency, standing in for a real block cipher. Counters go out to the lanes round-robin, and only while the four-entry keystream FIFO still has room for the result. A flush at each basic-block entry does four things: it loads a new nonce, restarts the counter at zero, empties the FIFO and aborts all lane work. The first instruction of a block therefore waits 13 cycles. After that, sequential code is never stalled, because keystream is fetched ahead and each block serves four instructions.

A small controller has three states:
- `S_IDLE` means no session. It is the only state in which the session key can be loaded.
- `S_WARM` means flushed and waiting for the first block.
- `S_RUN` means keystream is flowing.

The transitions are:
- `S_IDLE` to `S_WARM` on flush.
- `S_WARM` to `S_RUN` when the first block lands in the FIFO.
- `S_RUN` to `S_WARM` on flush, and `S_WARM` to `S_WARM` on flush.
- `S_WARM` or `S_RUN` to `S_IDLE` on session end.

Top module: `ksd_fetch_decrypt`

## Requirements
- R1: Take block n = fetch_idx[11:2] and lane j = fetch_idx[1:0]. When an instruction is taken, insn_out equals fetch_word XOR bits [32j+31:32j] of keystream block n.
- R2: Let K be the session key and N the 96-bit nonce. Keystream block n is M applied 12 times to ({N, n as 32 bits} XOR K), where M(x) = rotl(x,7) XOR (x >> 11) XOR K.
- R3: While fetch_req is high, exactly one of insn_valid and stall is high. While fetch_req is low, both are low.
- R4: Suppose flush is high in cycle f and fetch_req is held high with index 0 from cycle f+1. Then stall is high in cycles f+1 to f+13, and insn_valid is high in cycle f+14.
- R5: After warm-up, taking consecutive indices, in any pattern of idle cycles, never raises stall.
- R6: A flush in the middle of a block sequence discards all buffered and in-flight keystream. Decryption then uses the new nonce from block 0, after a fresh 13-cycle warm-up.
- R7: At most four keystream blocks are outstanding, counting both buffered and in-flight blocks. A long pause in fetching loses no keystream block and corrupts none.
- R8: key_load takes key_in only in S_IDLE. In S_WARM or S_RUN it is ignored, and decryption keeps using the earlier key.
- R9: A session end returns the block to S_IDLE. Every later fetch stalls until the next flush.
- R10: After reset, the block is in S_IDLE, holds no keystream, and a requested fetch stalls with insn_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Load key_in as the session key (accepted only in S_IDLE) |
| key_in | input | 128 | Session key value |
| sess_end | input | 1 | End the session and return to S_IDLE |
| flush | input | 1 | Basic-block entry: new nonce, counter restart, keystream discarded |
| flush_nonce | input | 96 | Nonce for the basic block being entered |
| fetch_req | input | 1 | Decode takes an instruction this cycle |
| fetch_idx | input | 12 | Instruction index within the current basic block |
| fetch_word | input | 32 | Encrypted instruction word |
| insn_out | output | 32 | Decrypted instruction |
| insn_valid | output | 1 | insn_out is valid and taken |
| stall | output | 1 | Keystream not ready; hold the pipeline |

## Verification
The plaintext, insn_valid and stall are combinational from the fetch inputs and the FIFO head, so they are due in the same cycle as the request. The bench samples them 2 ns after driving the inputs on the falling edge. A counter issued in cycle t lands in the FIFO at the edge that ends cycle t+12, so the first fetch after a flush is due valid exactly 14 cycles after the flush cycle. The bench counts stalled cycles one by one from the cycle after the flush and expects exactly 13. Key loads, session ends and flushes take effect at the next edge, so the bench checks their effect in the cycles that follow.

// File: rtl/ksd_pkg.sv
package ksd_pkg;
    localparam int KS_W   = 128;
    localparam int INSN_W = 32;
    localparam int SLICES = KS_W / INSN_W;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WARM = 2'd1,
        S_RUN  = 2'd2
    } ksd_state_e;

    // One round of the keyed stand-in mixer.
    function automatic logic [KS_W-1:0] ksd_round(input logic [KS_W-1:0] x,
                                                  input logic [KS_W-1:0] k);
        return {x[KS_W-8:0], x[KS_W-1:KS_W-7]} ^ (x >> 11) ^ k;
    endfunction
endpackage

// File: rtl/ksd_lane.sv
module ksd_lane
    import ksd_pkg::*;
#(
    parameter int LAT = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            start,
    input  logic [KS_W-1:0] ctr,
    input  logic [KS_W-1:0] key,
    output logic            busy,
    output logic            done,
    output logic [KS_W-1:0] ks
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]   cnt_q;
    logic [KS_W-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            st_q  <= '0;
        end else if (abort) begin
            busy  <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(LAT - 1);
            st_q  <= ctr ^ key;
        end else if (busy) begin
            if (cnt_q == CW'(1)) begin
                busy <= 1'b0;
            end else begin
                st_q  <= ksd_round(st_q, key);
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign done = busy && (cnt_q == CW'(1));
    assign ks   = ksd_round(st_q, key);
endmodule

// File: rtl/ksd_fifo.sv
module ksd_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 138
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
            cnt  <= '0;
        end else if (clr) begin
            wp_q <= '0;
            rp_q <= '0;
            cnt  <= '0;
        end else begin
            if (push) wp_q <= nxt(wp_q);
            if (pop)  rp_q <= nxt(rp_q);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wp_q] <= din;
    end

    assign dout  = mem[rp_q];
    assign empty = (cnt == '0);
endmodule

// File: rtl/ksd_fetch_decrypt.sv
module ksd_fetch_decrypt
    import ksd_pkg::*;
#(
    parameter int IDX_W = 12,
    parameter int LANES = 4,
    parameter int LAT   = 13,
    parameter int DEPTH = 4,
    parameter int CTR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    key_load,
    input  logic [KS_W-1:0]         key_in,
    input  logic                    sess_end,
    input  logic                    flush,
    input  logic [KS_W-CTR_W-1:0]   flush_nonce,
    input  logic                    fetch_req,
    input  logic [IDX_W-1:0]        fetch_idx,
    input  logic [INSN_W-1:0]       fetch_word,
    output logic [INSN_W-1:0]       insn_out,
    output logic                    insn_valid,
    output logic                    stall
);
    localparam int NONCE_W = KS_W - CTR_W;
    localparam int SEL_W   = $clog2(SLICES);
    localparam int BLK_W   = IDX_W - SEL_W;
    localparam int FW      = BLK_W + KS_W;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int OCC_W   = CNT_W + 1;
    localparam int RR_W    = (LANES > 1) ? $clog2(LANES) : 1;

    ksd_state_e          state_q, state_d;
    logic                run_en, key_open;
    logic [KS_W-1:0]     key_q;
    logic [NONCE_W-1:0]  nonce_q;
    logic [BLK_W-1:0]    nb_q;
    logic [OCC_W-1:0]    occ_q;
    logic [RR_W-1:0]     rr_q;

    logic [LANES-1:0]    lane_busy, lane_done;
    logic [KS_W-1:0]     lane_ks  [LANES];
    logic [BLK_W-1:0]    lane_tag_q [LANES];

    logic                clr, issue, push, pop, hit;
    logic [FW-1:0]       push_data, head;
    logic [CNT_W-1:0]    fifo_cnt;
    logic                fifo_empty;
    logic [KS_W-1:0]     ctr;
    logic [INSN_W-1:0]   slice;
    logic [OCC_W-1:0]    occ_after;
    logic [SEL_W-1:0]    sel;
    logic [BLK_W-1:0]    blk;

    assign clr = flush | sess_end;
    assign sel = fetch_idx[SEL_W-1:0];
    assign blk = fetch_idx[IDX_W-1:SEL_W];

    // ---------------- controller: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (flush && !sess_end) state_d = S_WARM;
            S_WARM: begin
                if (sess_end)   state_d = S_IDLE;
                else if (flush) state_d = S_WARM;
                else if (push)  state_d = S_RUN;
            end
            S_RUN: begin
                if (sess_end)   state_d = S_IDLE;
                else if (flush) state_d = S_WARM;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- controller: outputs ----------------
    always_comb begin
        run_en   = 1'b0;
        key_open = 1'b0;
        unique case (state_q)
            S_IDLE: key_open = 1'b1;
            S_WARM: run_en   = 1'b1;
            S_RUN:  run_en   = 1'b1;
            default: begin
                run_en   = 1'b0;
                key_open = 1'b0;
            end
        endcase
    end

    // ---------------- session registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q   <= '0;
            nonce_q <= '0;
        end else begin
            if (key_open && key_load)  key_q   <= key_in;
            if (flush && !sess_end)    nonce_q <= flush_nonce;
        end
    end

    // ---------------- issue control ----------------
    assign occ_after = occ_q - OCC_W'(pop);
    assign issue = run_en && !clr && !lane_busy[rr_q] && (occ_after < OCC_W'(DEPTH));
    assign ctr   = {nonce_q, {(CTR_W-BLK_W){1'b0}}, nb_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
            rr_q  <= '0;
            nb_q  <= '0;
        end else if (clr) begin
            occ_q <= '0;
            rr_q  <= '0;
            nb_q  <= '0;
        end else begin
            occ_q <= occ_q + OCC_W'(issue) - OCC_W'(pop);
            if (issue) begin
                rr_q <= (rr_q == RR_W'(LANES - 1)) ? '0 : rr_q + RR_W'(1);
                nb_q <= nb_q + BLK_W'(1);
            end
        end
    end

    // ---------------- cipher lanes ----------------
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic start_i;
        assign start_i = issue && (rr_q == RR_W'(i));

        ksd_lane #(.LAT(LAT)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .abort (clr),
            .start (start_i),
            .ctr   (ctr),
            .key   (key_q),
            .busy  (lane_busy[i]),
            .done  (lane_done[i]),
            .ks    (lane_ks[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lane_tag_q[i] <= '0;
            else if (start_i) lane_tag_q[i] <= nb_q;
        end
    end

    always_comb begin
        push_data = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_done[i]) push_data = {lane_tag_q[i], lane_ks[i]};
        end
    end

    assign push = (|lane_done) && !clr;

    // ---------------- keystream buffer ----------------
    ksd_fifo #(.DEPTH(DEPTH), .W(FW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (push),
        .din   (push_data),
        .pop   (pop),
        .dout  (head),
        .cnt   (fifo_cnt),
        .empty (fifo_empty)
    );

    // ---------------- slice select and XOR ----------------
    assign hit = !fifo_empty && (head[FW-1:KS_W] == blk);
    assign pop = fetch_req && hit && (sel == SEL_W'(SLICES - 1));

    always_comb begin
        slice = '0;
        for (int j = 0; j < SLICES; j++) begin
            if (sel == SEL_W'(j)) slice = head[j*INSN_W +: INSN_W];
        end
    end

    assign insn_out   = fetch_word ^ slice;
    assign insn_valid = fetch_req && hit;
    assign stall      = fetch_req && !hit;
endmodule

// File: rtl/ksd_checker.sv
module ksd_checker
    import ksd_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3,
    parameter int OCC_W = 4,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_req,
    input logic             insn_valid,
    input logic             stall,
    input logic             flush,
    input logic             sess_end,
    input ksd_state_e       state_q,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic [OCC_W-1:0] occ_q,
    input logic [LANES-1:0] lane_done,
    input logic             pop
);
    a_r3_one_of_two: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (insn_valid != stall));

    a_r3_quiet_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |-> (!insn_valid && !stall));

    a_r7_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= DEPTH);

    a_r7_outstanding_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_q) <= DEPTH);

    a_r7_buffered_within_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= int'(occ_q));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || sess_end) |=> (fifo_cnt == '0 && occ_q == '0));

    a_r4_stall_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && fetch_req) |-> stall);

    a_r2_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_done));

    a_r9_idle_holds_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (occ_q == '0 && fifo_cnt == '0));

    a_r5_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fifo_cnt != '0));
endmodule

bind ksd_fetch_decrypt ksd_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .OCC_W (OCC_W),
    .LANES (LANES)
) u_ksd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_req  (fetch_req),
    .insn_valid (insn_valid),
    .stall      (stall),
    .flush      (flush),
    .sess_end   (sess_end),
    .state_q    (state_q),
    .fifo_cnt   (fifo_cnt),
    .occ_q      (occ_q),
    .lane_done  (lane_done),
    .pop        (pop)
);

// File: tb/tb_ksd_fetch_decrypt.sv
`timescale 1ns/1ps
module tb_ksd_fetch_decrypt;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [127:0] key_in = '0;
    logic         sess_end = 1'b0;
    logic         flush = 1'b0;
    logic [95:0]  flush_nonce = '0;
    logic         fetch_req = 1'b0;
    logic [11:0]  fetch_idx = '0;
    logic [31:0]  fetch_word = '0;
    logic [31:0]  insn_out;
    logic         insn_valid;
    logic         stall;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [127:0] key_m;
    logic [95:0]  nonce_m;

    always #4 clk = ~clk;

    ksd_fetch_decrypt dut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .sess_end(sess_end), .flush(flush), .flush_nonce(flush_nonce),
        .fetch_req(fetch_req), .fetch_idx(fetch_idx), .fetch_word(fetch_word),
        .insn_out(insn_out), .insn_valid(insn_valid), .stall(stall)
    );

    function automatic logic [127:0] mix(input logic [127:0] x, input logic [127:0] k);
        return {x[120:0], x[127:121]} ^ (x >> 11) ^ k;
    endfunction

    function automatic logic [31:0] expect_insn(input logic [127:0] k, input logic [95:0] n,
                                                input logic [11:0] idx, input logic [31:0] w);
        logic [127:0] x;
        x = {n, 22'd0, idx[11:2]} ^ k;
        for (int r = 0; r < 12; r++) x = mix(x, k);
        return w ^ x[idx[1:0]*32 +: 32];
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_flush(input logic [95:0] n);
        flush = 1'b1; flush_nonce = n; fetch_req = 1'b0;
        nonce_m = n;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // First fetch after a flush: count stalls, expect 13 (R4).
    task automatic warm_up();
        int stalls = 0;
        fetch_req = 1'b1; fetch_idx = '0; fetch_word = $urandom;
        for (int c = 0; c < 60; c++) begin
            #2;
            if (!stall) break;
            stalls++;
            @(negedge clk);
        end
        check(stalls == 13, "R4 warm-up stall count", stalls, 13);
        check(insn_valid && insn_out == expect_insn(key_m, nonce_m, 12'd0, fetch_word),
              "R1 first word after warm-up", insn_out,
              expect_insn(key_m, nonce_m, 12'd0, fetch_word));
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic run_seq(input int first, input int n, input int gapmax, input string tag);
        for (int i = 0; i < n; i++) begin
            int gap;
            gap = (gapmax > 0) ? int'($urandom_range(gapmax, 0)) : 0;
            for (int g = 0; g < gap; g++) begin
                fetch_req = 1'b0;
                #2;
                check(!insn_valid && !stall, "R3 no request quiet", {insn_valid, stall}, 0);
                @(negedge clk);
            end
            fetch_req = 1'b1; fetch_idx = 12'(first + i); fetch_word = $urandom;
            #2;
            check(!stall, {"R5 no stall in sequence ", tag}, stall, 0);
            check(insn_valid && insn_out == expect_insn(key_m, nonce_m, fetch_idx, fetch_word),
                  {"R1 R2 decrypt ", tag}, insn_out,
                  expect_insn(key_m, nonce_m, fetch_idx, fetch_word));
            @(negedge clk);
        end
        fetch_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state stalls a request
        for (int c = 0; c < 3; c++) begin
            fetch_req = 1'b1; fetch_idx = '0;
            #2;
            check(stall && !insn_valid, "R10 reset stalls fetch", {insn_valid, stall}, 1);
            @(negedge clk);
        end
        fetch_req = 1'b0;

        // Load key in idle (R8), enter block
        key_m = {$urandom, $urandom, $urandom, $urandom};
        key_load = 1'b1; key_in = key_m;
        @(negedge clk);
        key_load = 1'b0;
        do_flush({$urandom, $urandom, $urandom});
        warm_up();
        run_seq(1, 40, 0, "back-to-back");
        run_seq(41, 40, 3, "with gaps");

        // R8: key load while running is ignored
        key_load = 1'b1; key_in = ~key_m;
        @(negedge clk);
        key_load = 1'b0;
        run_seq(81, 40, 1, "R8 key ignored while running");

        // R6: mid-block flush, new nonce
        do_flush({$urandom, $urandom, $urandom});
        warm_up();
        run_seq(1, 21, 0, "R6 after mid flush");
        do_flush({$urandom, $urandom, $urandom});
        warm_up();

        // R7: long pause, buffer fills, nothing lost
        fetch_req = 1'b0;
        repeat (50) @(negedge clk);
        run_seq(1, 48, 0, "R7 after long pause");

        // R9: session end then stalls
        sess_end = 1'b1;
        @(negedge clk);
        sess_end = 1'b0;
        for (int c = 0; c < 20; c++) begin
            fetch_req = 1'b1; fetch_idx = 12'd49;
            #2;
            if (c % 5 == 0 || c == 19)
                check(stall && !insn_valid, "R9 stalls after session end", {insn_valid, stall}, 1);
            @(negedge clk);
        end
        fetch_req = 1'b0;

        // R8: new key accepted in idle
        key_m = {$urandom, $urandom, $urandom, $urandom};
        key_load = 1'b1; key_in = key_m;
        @(negedge clk);
        key_load = 1'b0;
        do_flush({$urandom, $urandom, $urandom});
        warm_up();
        run_seq(1, 30, 2, "R8 new key after idle");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule